// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block is the device-side logic behind table-based message-signalled interrupts. It stores, for each of a parameterised number of vectors, a 64-bit message address, a 32-bit message data word and a per-vector mask bit. It also keeps a packed pending-bit array and a per-vector use count. Software reaches the table and the pending array through a 32-bit register port. A separate control-write port updates the function enable and mask-all bits.

Internal sources raise a vector on a valid/ready trigger port. If the vector is unmasked, the block puts one address/data message on a valid/ready output. If it is masked, the block records the vector as pending. When a vector's effective mask drops while its pending bit is set, the block clears the bit and sends the message. After a function-mask change or a table write that unmasks a vector, a sequential scan (one vector per clock, lowest first) does this replay while `busy` is high.

Top module: `msix_vector_ctrl`

## Requirements
- R1: A vector's effective mask is its own mask bit OR the function mask. The function mask (output `fnMasked`) is 1 when the enable bit is 0 or the mask-all bit is 1.
- R2: A trigger whose index is NumVec or greater, or whose vector has a use count of zero, is accepted and dropped: no message is sent and no pending bit changes.
- R3: An accepted trigger on a used, masked vector sets its pending bit and sends nothing. On a used, unmasked vector it sends one message: address {high word, low word} of the entry and its data word, with msgValid high from the following cycle.
- R4: A table write that clears a vector's mask bit while the function mask is 0 makes the block send that vector's pending message, if the vector is used, and clear its pending bit. No pending bit stays set on an unmasked vector once `busy` is low.
- R5: Reads of pending-array word w return vector 32*w+b in bit b (eight vectors per byte, little-endian). Writes to the pending array change nothing.
- R6: Each entry occupies 16 bytes at byte address 16*v: address low at +0, address high at +4, data at +8, and vector control at +12 with the mask in bit 0 (other bits read 0). Only accesses with addr[1:0]=0 take effect; unaligned reads return 0. Read data appears on regRdata one cycle after the request.
- R7: A control write that leaves the enable bit set pulses intxDeassert high in the following cycle.
- R8: A function-mask change starts a scan of one vector per clock with `busy` high. Replays leave in ascending vector order. A replay that finds the output occupied stalls the scan. `trigReady` is low while `busy` is high.
- R9: Reset clears enable, mask-all, all addresses, data, pending bits and use counts, and sets every vector's mask bit.
- R10: A use-count request increments or decrements one vector's count. Increments saturate at the maximum count. A decrement that reaches zero clears the vector's pending bit. Decrements of a zero count, and requests for out-of-range vectors, are ignored.
- R11: While msgValid is high and msgReady is low, msgValid, msgAddr and msgData hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regPba | input | 1 | 1 = pending array, 0 = vector table |
| regAddr | input | AddrW | Byte address within the selected space |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after request |
| ctlWrite | input | 1 | Control-byte write strobe |
| ctlEnable | input | 1 | New enable bit |
| ctlMaskAll | input | 1 | New mask-all bit |
| fnMasked | output | 1 | Current function mask |
| intxDeassert | output | 1 | Legacy line deassert pulse |
| useValid | input | 1 | Use-count request |
| useInc | input | 1 | 1 = increment, 0 = decrement |
| useVec | input | IdxW | Vector for the use-count request |
| trigValid | input | 1 | Trigger request |
| trigVec | input | IdxW | Triggered vector |
| trigReady | output | 1 | Trigger accepted this cycle |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Message consumer ready |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data |
| busy | output | 1 | Replay scan in progress |

## Verification
The delivery path is swept with every vector programmed to a distinct address and data. Triggers are applied in four states: use count zero, function-masked, own-bit-masked and fully unmasked. Together these separate a dropped trigger, a recorded one and a sent one. Replays are provoked in two ways, by a table unmask and by a function-mask change, so that the ordering and the output stall can be told apart. The use-count sequences step through zero and saturation, so that a wrapping counter or a missing pending clear shows up as a wrong pending word.

// File: rtl/msix_pkg.sv
package msix_pkg;
  typedef struct packed {
    logic setPend;
    logic clrPend;
  } pendStrobe_t;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_VCTRL   = 2'd3
  } entryWord_e;
endpackage

// File: rtl/msix_vec_store.sv
module msix_vec_store
  import msix_pkg::*;
#(
  parameter int NumVec = 8,
  parameter int CountW = 3,
  parameter int IdxW   = 4,
  parameter int AddrW  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic              regPba,
  input  logic [AddrW-1:0]  regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              ctlWrite,
  input  logic              ctlEnable,
  input  logic              ctlMaskAll,
  output logic              fnMasked,
  output logic              intxDeassert,
  input  logic              useValid,
  input  logic              useInc,
  input  logic [IdxW-1:0]   useVec,
  input  pendStrobe_t       strobe,
  input  logic [IdxW-1:0]   pendIdx,
  input  logic [IdxW-1:0]   lookIdx,
  output logic [63:0]       lookAddr,
  output logic [31:0]       lookData,
  output logic [NumVec-1:0] effMask,
  output logic [NumVec-1:0] pendVec,
  output logic [NumVec-1:0] usedVec,
  output logic              kickScan
);
  localparam int SelW = $clog2(NumVec);
  localparam int PbaW = AddrW - 2;

  logic [31:0]       addrLoQ [NumVec];
  logic [31:0]       addrHiQ [NumVec];
  logic [31:0]       dataQ   [NumVec];
  logic [CountW-1:0] cntQ    [NumVec];
  logic [NumVec-1:0] maskQ, pendQ;
  logic              enQ, maskAllQ, intxQ;
  logic [31:0]       rdataQ, rdNext;

  logic [SelW-1:0] vecSel;
  entryWord_e      wordSel;
  logic            aligned, inTbl, tblWr, newFn, ctlKick, tblKick, curMask;

  assign fnMasked = !enQ || maskAllQ;
  assign aligned  = (regAddr[1:0] == 2'b00);
  assign vecSel   = regAddr[SelW+3:4];
  assign wordSel  = entryWord_e'(regAddr[3:2]);
  assign inTbl    = ({1'b0, vecSel} < (SelW+1)'(NumVec));
  assign tblWr    = regValid && regWrite && !regPba && aligned && inTbl;
  assign newFn    = !ctlEnable || ctlMaskAll;
  assign ctlKick  = ctlWrite && (newFn != fnMasked);

  always_comb begin
    curMask = 1'b0;
    for (int v = 0; v < NumVec; v++)
      if (vecSel == SelW'(v)) curMask = maskQ[v];
  end

  // any unmask transition restarts the scan, pending or not
  assign tblKick  = tblWr && (wordSel == W_VCTRL) && curMask && !regWdata[0] && !fnMasked;
  assign kickScan = ctlKick || tblKick;

  always_comb begin
    for (int v = 0; v < NumVec; v++) begin
      effMask[v] = maskQ[v] || fnMasked;
      usedVec[v] = (cntQ[v] != '0);
    end
    pendVec = pendQ;
  end

  always_comb begin
    lookAddr = '0;
    lookData = '0;
    for (int v = 0; v < NumVec; v++)
      if (lookIdx == IdxW'(v)) begin
        lookAddr = {addrHiQ[v], addrLoQ[v]};
        lookData = dataQ[v];
      end
  end

  always_comb begin
    rdNext = '0;
    if (aligned && regPba) begin
      for (int v = 0; v < NumVec; v++)
        if (regAddr[AddrW-1:2] == PbaW'(v / 32)) rdNext[v % 32] = pendQ[v];
    end else if (aligned && inTbl) begin
      for (int v = 0; v < NumVec; v++)
        if (vecSel == SelW'(v)) begin
          case (wordSel)
            W_ADDR_LO: rdNext = addrLoQ[v];
            W_ADDR_HI: rdNext = addrHiQ[v];
            W_DATA:    rdNext = dataQ[v];
            default:   rdNext = {31'b0, maskQ[v]};
          endcase
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enQ      <= 1'b0;
      maskAllQ <= 1'b0;
      intxQ    <= 1'b0;
      rdataQ   <= '0;
      maskQ    <= '1;
      pendQ    <= '0;
      for (int v = 0; v < NumVec; v++) begin
        addrLoQ[v] <= '0;
        addrHiQ[v] <= '0;
        dataQ[v]   <= '0;
        cntQ[v]    <= '0;
      end
    end else begin
      intxQ <= ctlWrite && ctlEnable;
      if (ctlWrite) begin
        enQ      <= ctlEnable;
        maskAllQ <= ctlMaskAll;
      end
      if (regValid && !regWrite) rdataQ <= rdNext;
      for (int v = 0; v < NumVec; v++) begin
        if (tblWr && vecSel == SelW'(v)) begin
          case (wordSel)
            W_ADDR_LO: addrLoQ[v] <= regWdata;
            W_ADDR_HI: addrHiQ[v] <= regWdata;
            W_DATA:    dataQ[v]   <= regWdata;
            default:   maskQ[v]   <= regWdata[0];
          endcase
        end
        if (useValid && useVec == IdxW'(v)) begin
          if (useInc && cntQ[v] != '1)       cntQ[v] <= cntQ[v] + 1'b1;
          else if (!useInc && cntQ[v] != '0) cntQ[v] <= cntQ[v] - 1'b1;
        end
        if (strobe.setPend && pendIdx == IdxW'(v)) pendQ[v] <= 1'b1;
        if ((strobe.clrPend && pendIdx == IdxW'(v)) ||
            (useValid && !useInc && useVec == IdxW'(v) && cntQ[v] == CountW'(1)))
          pendQ[v] <= 1'b0;
      end
    end
  end

  assign regRdata     = rdataQ;
  assign intxDeassert = intxQ;

  // R5: a pending-array write alone never moves a pending bit
  p_pba_readonly_r5: assert property (@(posedge clk) disable iff (!rst_n)
    regValid && regWrite && regPba && !strobe.setPend && !strobe.clrPend &&
    !(useValid && !useInc) |=> $stable(pendQ));

  // R7: the deassert pulse follows a control write that leaves the function enabled
  p_intx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    intxDeassert |-> enQ);
endmodule

// File: rtl/msix_deliver.sv
module msix_deliver
  import msix_pkg::*;
#(
  parameter int NumVec = 8,
  parameter int IdxW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigValid,
  input  logic [IdxW-1:0]   trigVec,
  output logic              trigReady,
  input  logic              kickScan,
  input  logic [NumVec-1:0] effMask,
  input  logic [NumVec-1:0] pendVec,
  input  logic [NumVec-1:0] usedVec,
  input  logic [63:0]       lookAddr,
  input  logic [31:0]       lookData,
  output logic [IdxW-1:0]   lookIdx,
  output pendStrobe_t       strobe,
  output logic [IdxW-1:0]   pendIdx,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [63:0]       msgAddr,
  output logic [31:0]       msgData,
  output logic              busy
);
  localparam int SelW = $clog2(NumVec);

  logic            busyQ, msgValidQ;
  logic [IdxW-1:0] scanQ;
  logic [63:0]     msgAddrQ;
  logic [31:0]     msgDataQ;

  logic [SelW-1:0] trigSel, scanSel;
  logic slotFree, trigAcc, trigIn, trigUsed, trigMasked;
  logic scanHit, scanSend, scanStall, scanStep, loadMsg;

  assign slotFree   = !msgValidQ || msgReady;
  assign trigReady  = !busyQ && slotFree;
  assign trigAcc    = trigValid && trigReady;
  assign trigSel    = trigVec[SelW-1:0];
  assign scanSel    = scanQ[SelW-1:0];
  assign trigIn     = (trigVec < IdxW'(NumVec));
  assign trigUsed   = trigIn && usedVec[trigSel];
  assign trigMasked = effMask[trigSel];

  assign scanHit   = busyQ && pendVec[scanSel] && !effMask[scanSel];
  assign scanSend  = scanHit && usedVec[scanSel];
  assign scanStall = scanSend && !slotFree;
  assign scanStep  = busyQ && !scanStall;

  assign lookIdx        = busyQ ? scanQ : trigVec;
  assign pendIdx        = busyQ ? scanQ : trigVec;
  assign strobe.setPend = trigAcc && trigUsed && trigMasked;
  assign strobe.clrPend = scanHit && !scanStall;
  assign loadMsg        = (trigAcc && trigUsed && !trigMasked) || (scanSend && slotFree);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msgValidQ <= 1'b0;
      msgAddrQ  <= '0;
      msgDataQ  <= '0;
      busyQ     <= 1'b0;
      scanQ     <= '0;
    end else begin
      if (loadMsg) begin
        msgValidQ <= 1'b1;
        msgAddrQ  <= lookAddr;
        msgDataQ  <= lookData;
      end else if (msgReady) begin
        msgValidQ <= 1'b0;
      end
      if (kickScan) begin
        busyQ <= 1'b1;
        scanQ <= '0;
      end else if (scanStep) begin
        if (scanQ == IdxW'(NumVec - 1)) busyQ <= 1'b0;
        else                            scanQ <= scanQ + 1'b1;
      end
    end
  end

  assign msgValid = msgValidQ;
  assign msgAddr  = msgAddrQ;
  assign msgData  = msgDataQ;
  assign busy     = busyQ;

  // R11: an unconsumed message does not move
  p_msg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msgValidQ && !msgReady |=> msgValidQ && $stable(msgAddrQ) && $stable(msgDataQ));

  // R4: outside a scan no unmasked vector is left pending
  p_no_stray_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busyQ |-> ((pendVec & ~effMask) == '0));

  // R8: the scan pointer stays inside the table
  p_scan_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ |-> (scanQ < IdxW'(NumVec)));

  // R2: a dropped trigger leaves the output empty
  p_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trigAcc && !trigUsed |=> !msgValidQ);
endmodule

// File: rtl/msix_vector_ctrl.sv
module msix_vector_ctrl
  import msix_pkg::*;
#(
  parameter  int NumVec = 8,
  parameter  int CountW = 3,
  localparam int IdxW   = $clog2(NumVec) + 1,
  localparam int AddrW  = $clog2(NumVec) + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regValid,
  input  logic             regWrite,
  input  logic             regPba,
  input  logic [AddrW-1:0] regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             ctlWrite,
  input  logic             ctlEnable,
  input  logic             ctlMaskAll,
  output logic             fnMasked,
  output logic             intxDeassert,
  input  logic             useValid,
  input  logic             useInc,
  input  logic [IdxW-1:0]  useVec,
  input  logic             trigValid,
  input  logic [IdxW-1:0]  trigVec,
  output logic             trigReady,
  output logic             msgValid,
  input  logic             msgReady,
  output logic [63:0]      msgAddr,
  output logic [31:0]      msgData,
  output logic             busy
);
  pendStrobe_t       strobe;
  logic [IdxW-1:0]   pendIdx, lookIdx;
  logic [63:0]       lookAddr;
  logic [31:0]       lookData;
  logic [NumVec-1:0] effMask, pendVec, usedVec;
  logic              kickScan;

  msix_vec_store #(.NumVec(NumVec), .CountW(CountW), .IdxW(IdxW), .AddrW(AddrW)) store_i (
    .clk, .rst_n, .regValid, .regWrite, .regPba, .regAddr, .regWdata, .regRdata,
    .ctlWrite, .ctlEnable, .ctlMaskAll, .fnMasked, .intxDeassert,
    .useValid, .useInc, .useVec, .strobe, .pendIdx, .lookIdx,
    .lookAddr, .lookData, .effMask, .pendVec, .usedVec, .kickScan
  );

  msix_deliver #(.NumVec(NumVec), .IdxW(IdxW)) deliver_i (
    .clk, .rst_n, .trigValid, .trigVec, .trigReady, .kickScan,
    .effMask, .pendVec, .usedVec, .lookAddr, .lookData, .lookIdx,
    .strobe, .pendIdx, .msgValid, .msgReady, .msgAddr, .msgData, .busy
  );
endmodule

// File: tb/msix_vector_ctrl_tb.sv
module msix_vector_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int IW = 4;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regValid = 0, regWrite = 0, regPba = 0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic ctlWrite = 0, ctlEnable = 0, ctlMaskAll = 0, fnMasked, intxDeassert;
  logic useValid = 0, useInc = 0;
  logic [IW-1:0] useVec = '0;
  logic trigValid = 0;
  logic [IW-1:0] trigVec = '0;
  logic trigReady, msgValid, msgReady = 1'b1, busy;
  logic [63:0] msgAddr;
  logic [31:0] msgData;

  int nChecks = 0, nFails = 0, logCount = 0;
  logic [63:0] logAddr [64];
  logic [31:0] logData [64];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msix_vector_ctrl #(.NumVec(NV), .CountW(3)) dut_i (.*);

  always @(negedge clk)
    if (rst_n && msgValid && msgReady && logCount < 64) begin
      logAddr[logCount] = msgAddr;
      logData[logCount] = msgData;
      logCount++;
    end

  function automatic logic [63:0] expAddr(int v);
    return {32'h0000_00B0 + 32'(v), 32'hA000_0000 + 32'(v * 16)};
  endfunction
  function automatic logic [31:0] expData(int v);
    return 32'hD000_0000 + 32'(v);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic regWr(input logic pba, input int addr, input logic [31:0] d);
    regValid = 1; regWrite = 1; regPba = pba; regAddr = AW'(addr); regWdata = d;
    tick(1);
    regValid = 0; regWrite = 0;
  endtask

  task automatic regRd(input logic pba, input int addr, output logic [31:0] d);
    regValid = 1; regWrite = 0; regPba = pba; regAddr = AW'(addr);
    tick(1);
    d = regRdata;
    regValid = 0;
  endtask

  task automatic ctlWr(input logic en, input logic ma);
    ctlWrite = 1; ctlEnable = en; ctlMaskAll = ma;
    tick(1);
    ctlWrite = 0;
    chk("R7 intx pulse", 64'(intxDeassert), 64'(en));
    chk("R1 function mask", 64'(fnMasked), 64'(!en || ma));
  endtask

  task automatic useOp(input logic inc, input int v);
    useValid = 1; useInc = inc; useVec = IW'(v);
    tick(1);
    useValid = 0;
  endtask

  task automatic trig(input int v);
    trigValid = 1; trigVec = IW'(v);
    while (!trigReady) tick(1);
    tick(1);
    trigValid = 0;
    tick(2);
  endtask

  task automatic waitIdle();
    tick(1);
    while (busy) tick(1);
    tick(2);
  endtask

  task automatic checkReset(string tag);
    logic [31:0] d;
    chk({tag, " R9 fnMasked"}, 64'(fnMasked), 64'd1);
    regRd(1, 0, d);
    chk({tag, " R9 pending"}, 64'(d), 64'd0);
    for (int v = 0; v < NV; v++)
      for (int w = 0; w < 4; w++) begin
        regRd(0, v * 16 + w * 4, d);
        chk({tag, " R9 entry"}, 64'(d), (w == 3) ? 64'd1 : 64'd0);
      end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst_n = 1;
    tick(1);
    checkReset("initial");
    chk("R8 trigReady idle", 64'(trigReady), 64'd1);

    // program table, sweep readback
    for (int v = 0; v < NV; v++) begin
      regWr(0, v * 16 + 0, expAddr(v)[31:0]);
      regWr(0, v * 16 + 4, expAddr(v)[63:32]);
      regWr(0, v * 16 + 8, expData(v));
    end
    for (int v = 0; v < NV; v++) begin
      regRd(0, v * 16, d);      chk("R6 addr low", 64'(d), 64'(expAddr(v)[31:0]));
      regRd(0, v * 16 + 4, d);  chk("R6 addr high", 64'(d), 64'(expAddr(v)[63:32]));
      regRd(0, v * 16 + 8, d);  chk("R6 data", 64'(d), 64'(expData(v)));
    end
    regWr(0, 1, 32'hFFFF_FFFF);
    regRd(0, 0, d);  chk("R6 unaligned write ignored", 64'(d), 64'(expAddr(0)[31:0]));
    regRd(0, 2, d);  chk("R6 unaligned read zero", 64'(d), 64'd0);

    // R2: zero use count drops
    for (int v = 0; v < NV; v++) trig(v);
    regRd(1, 0, d);  chk("R2 unused drop pending", 64'(d), 64'd0);

    for (int v = 0; v < NV; v++) useOp(1, v);
    trig(9);
    regRd(1, 0, d);  chk("R2 out-of-range drop", 64'(d), 64'd0);

    // R3: masked triggers pend
    trig(1); trig(3); trig(6);
    regRd(1, 0, d);  chk("R3 R5 pending layout", 64'(d), 64'h4A);
    chk("R3 no message while masked", 64'(logCount), 64'd0);
    regWr(1, 0, 32'hFFFF_FFFF);
    regRd(1, 0, d);  chk("R5 pending write ignored", 64'(d), 64'h4A);

    // enable: own masks still set
    ctlWr(1, 0);
    waitIdle();
    chk("R1 own mask keeps pending", 64'(logCount), 64'd0);

    // R4: table unmask replays vector 3
    regWr(0, 3 * 16 + 12, 32'h0);
    waitIdle();
    chk("R4 replay count", 64'(logCount), 64'd1);
    chk("R4 replay addr", logAddr[0], expAddr(3));
    chk("R4 replay data", 64'(logData[0]), 64'(expData(3)));
    regRd(1, 0, d);  chk("R4 pending cleared", 64'(d), 64'h42);

    // R3: unmasked trigger sends
    trig(3);
    chk("R3 direct count", 64'(logCount), 64'd2);
    chk("R3 direct addr", logAddr[1], expAddr(3));
    trig(9);
    chk("R2 out-of-range no message", 64'(logCount), 64'd2);

    // R8: function-mask scan with stall
    ctlWr(1, 1);
    waitIdle();
    regWr(0, 1 * 16 + 12, 32'h0);
    regWr(0, 6 * 16 + 12, 32'h0);
    tick(2);
    chk("R1 mask-all holds", 64'(logCount), 64'd2);
    msgReady = 0;
    ctlWr(1, 0);
    tick(12);
    chk("R8 busy during stall", 64'(busy), 64'd1);
    chk("R8 trigReady low while busy", 64'(trigReady), 64'd0);
    chk("R11 held valid", 64'(msgValid), 64'd1);
    chk("R11 held addr", msgAddr, expAddr(1));
    regRd(1, 0, d);  chk("R8 vector6 still pending", 64'(d), 64'h40);
    msgReady = 1;
    waitIdle();
    chk("R8 scan count", 64'(logCount), 64'd4);
    chk("R8 first lowest", logAddr[2], expAddr(1));
    chk("R8 then vector6", logAddr[3], expAddr(6));
    regRd(1, 0, d);  chk("R8 pending empty", 64'(d), 64'd0);

    // R10: use counts (vector 5 still own-masked)
    trig(5);
    regRd(1, 0, d);  chk("R10 pend set", 64'(d), 64'h20);
    useOp(0, 5);
    regRd(1, 0, d);  chk("R10 dec to zero clears", 64'(d), 64'd0);
    trig(5);
    regRd(1, 0, d);  chk("R2 zero count drop", 64'(d), 64'd0);
    useOp(0, 5);
    useOp(1, 5);
    trig(5);
    regRd(1, 0, d);  chk("R10 zero dec ignored", 64'(d), 64'h20);
    useOp(0, 5);
    regRd(1, 0, d);  chk("R10 count was one", 64'(d), 64'd0);
    for (int i = 0; i < 8; i++) useOp(1, 7);
    for (int i = 0; i < 6; i++) useOp(0, 7);
    useOp(1, 12);
    trig(7);
    regRd(1, 0, d);  chk("R10 saturated count pends", 64'(d), 64'h80);
    useOp(0, 7);
    regRd(1, 0, d);  chk("R10 saturation", 64'(d), 64'd0);
    chk("R10 no stray messages", 64'(logCount), 64'd4);

    // R9: reset mid-run
    rst_n = 0;
    tick(2);
    rst_n = 1;
    tick(1);
    checkReset("rerun");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule